// File: doc/BRIEF.md
# Transaction-Ordered DRAM Command Scheduler with Early Row Preparation

This block picks one DRAM command per cycle from a small queue. Every queued entry carries a command type, a target bank, a row and the number of the oblivious-memory transaction it belongs to. Data commands must leave in strict transaction order, so that the bus pattern of one protected access never mixes with that of the next. Row preparation (precharge and activate) returns no data, so the scheduler may pull it forward. When nothing of the current transaction can go, a precharge or activate from the following transaction is sent to a bank that the current transaction no longer uses. The row-conflict penalty of the next transaction is then absorbed while the current one finishes.

The block keeps the open or closed state and the open row of every bank itself, and updates it as precharge and activate commands leave. The surrounding controller loads entries through a push port, supplies a can-issue strobe and a per-bank ready vector that stand for all DRAM timing, and forwards the issued command to the memory bus.

Top module: `txn_bank_scheduler`

## Requirements
- R1: After reset the queue is empty, every bank is precharged (closed), the current transaction number is 0, `enqReady` is 1 and `issValid` is 0.
- R2: At most one command issues per cycle. A command issues only while `canIssue` is 1 and its bank's `bankReady` bit is 1.
- R3: Among issuable commands of the current transaction, an RD or WR that hits the open row wins over a PRE or ACT. Ties go to the oldest entry. Within one transaction, commands to the same bank leave in arrival order.
- R4: Command codes are PRE=0, ACT=1, RD=2, WR=3. ACT issues only to a closed bank, PRE only to an open bank, and RD/WR only to an open bank whose open row equals the entry's row. An entry that breaks this waits and does not issue.
- R5: When no command of current transaction i can issue, a PRE or ACT of transaction i+1 may issue, with `issHoisted`=1. This needs two things: it is the oldest i+1 entry for its bank, and no entry of transaction i remains on that bank.
- R6: An RD or WR never issues while its transaction number differs from the current one.
- R7: A PRE or ACT of transaction i+1 that follows an older i+1 entry on the same bank (a conflict inside that transaction) is not pulled forward.
- R8: Entries whose transaction is neither i nor i+1 are never issued.
- R9: When the queue holds entries but none of transaction i, the current number steps to i+1 (modulo 2^TXN_W) at the next clock edge.
- R10: An issued entry leaves the queue. A PRE closes its bank and an ACT opens its bank on the entry's row. `enqReady` is 0 exactly when DEPTH entries are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Load one entry this cycle (taken when enqReady) |
| pushCmd | input | 2 | Command code of the pushed entry |
| pushBank | input | clog2(NUM_BANKS) | Target bank of the pushed entry |
| pushRow | input | ROW_W | Row of the pushed entry |
| pushTxn | input | TXN_W | Transaction number of the pushed entry |
| enqReady | output | 1 | Queue has a free slot |
| canIssue | input | 1 | Command bus may take a command this cycle |
| bankReady | input | NUM_BANKS | Per-bank ready from the timing logic |
| issValid | output | 1 | A command issues this cycle |
| issCmd | output | 2 | Issued command code |
| issBank | output | clog2(NUM_BANKS) | Issued bank |
| issRow | output | ROW_W | Issued row |
| issTxn | output | TXN_W | Transaction number of the issued entry |
| issHoisted | output | 1 | Issued command belongs to the next transaction |

## Verification
The selection is driven by several queue contents. A single transaction on one bank shows that bank state is tracked. A row hit queued behind an older activate separates first-ready from plain arrival order. A blocked current transaction, with preparation commands queued for the next one and for the one after, shows which of them may be pulled forward and which must wait. A next-transaction precharge placed behind its own transaction's data command tells a cross-transaction conflict apart from an internal one. Illegal activates and wrong-row writes, together with filling the queue, cover the legality rules and back-pressure.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;

  typedef enum logic [1:0] {
    CMD_PRE = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  // strobes from control to the queue datapath
  typedef struct packed {
    logic push;
    logic pop;
  } strobe_t;

  function automatic logic isDataCmd(cmd_e c);
    return (c == CMD_RD) || (c == CMD_WR);
  endfunction

endpackage

// File: rtl/bank_sched_dp.sv
module bank_sched_dp
  import bank_sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int TXN_W     = 4,
  parameter int BANK_W    = 3,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strb,
  input  logic [IDX_W-1:0]     popIdx,
  input  logic [1:0]           pushCmd,
  input  logic [BANK_W-1:0]    pushBank,
  input  logic [ROW_W-1:0]     pushRow,
  input  logic [TXN_W-1:0]     pushTxn,
  output logic [DEPTH-1:0]     qValid,
  output cmd_e                 qCmd  [DEPTH],
  output logic [BANK_W-1:0]    qBank [DEPTH],
  output logic [ROW_W-1:0]     qRow  [DEPTH],
  output logic [TXN_W-1:0]     qTxn  [DEPTH],
  output logic [NUM_BANKS-1:0] bankOpen,
  output logic [ROW_W-1:0]     openRow [NUM_BANKS],
  output logic [CNT_W-1:0]     count
);

  cmd_e              nCmd  [DEPTH];
  logic [BANK_W-1:0] nBank [DEPTH];
  logic [ROW_W-1:0]  nRow  [DEPTH];
  logic [TXN_W-1:0]  nTxn  [DEPTH];
  logic [CNT_W-1:0]  tail;
  logic [CNT_W-1:0]  cntNext;

  // entries form a contiguous prefix; index order is arrival order
  for (genvar g = 0; g < DEPTH; g++) begin : g_valid
    assign qValid[g] = (CNT_W'(g) < count);
  end

  always_comb begin
    tail    = count - CNT_W'(strb.pop);
    cntNext = count - CNT_W'(strb.pop) + CNT_W'(strb.push);
    for (int k = 0; k < DEPTH; k++) begin
      if (strb.pop && (k >= int'(popIdx)) && (k < DEPTH - 1)) begin
        nCmd[k]  = qCmd[(k + 1) % DEPTH];
        nBank[k] = qBank[(k + 1) % DEPTH];
        nRow[k]  = qRow[(k + 1) % DEPTH];
        nTxn[k]  = qTxn[(k + 1) % DEPTH];
      end else begin
        nCmd[k]  = qCmd[k];
        nBank[k] = qBank[k];
        nRow[k]  = qRow[k];
        nTxn[k]  = qTxn[k];
      end
      if (strb.push && (k == int'(tail))) begin
        nCmd[k]  = cmd_e'(pushCmd);
        nBank[k] = pushBank;
        nRow[k]  = pushRow;
        nTxn[k]  = pushTxn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count    <= '0;
      bankOpen <= '0;
      for (int b = 0; b < NUM_BANKS; b++) openRow[b] <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        qCmd[k]  <= CMD_PRE;
        qBank[k] <= '0;
        qRow[k]  <= '0;
        qTxn[k]  <= '0;
      end
    end else begin
      count <= cntNext;
      for (int k = 0; k < DEPTH; k++) begin
        qCmd[k]  <= nCmd[k];
        qBank[k] <= nBank[k];
        qRow[k]  <= nRow[k];
        qTxn[k]  <= nTxn[k];
      end
      if (strb.pop) begin
        if (qCmd[popIdx] == CMD_PRE) begin
          bankOpen[qBank[popIdx]] <= 1'b0;
        end else if (qCmd[popIdx] == CMD_ACT) begin
          bankOpen[qBank[popIdx]] <= 1'b1;
          openRow[qBank[popIdx]]  <= qRow[popIdx];
        end
      end
    end
  end

  p_pop_shrinks_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && !strb.push) |=> (count == $past(count) - CNT_W'(1)));

  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.push |-> (count < CNT_W'(DEPTH)) || strb.pop);

  p_act_closed_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && qCmd[popIdx] == CMD_ACT) |-> !bankOpen[qBank[popIdx]]);

  p_pre_closes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.pop && qCmd[popIdx] == CMD_PRE) |=> !bankOpen[$past(qBank[popIdx])]);

endmodule

// File: rtl/bank_sched_ctl.sv
module bank_sched_ctl
  import bank_sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int TXN_W     = 4,
  parameter int BANK_W    = 3,
  parameter int IDX_W     = 3,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 canIssue,
  input  logic [NUM_BANKS-1:0] bankReady,
  input  logic                 pushValid,
  input  logic [CNT_W-1:0]     count,
  input  logic [DEPTH-1:0]     qValid,
  input  cmd_e                 qCmd  [DEPTH],
  input  logic [BANK_W-1:0]    qBank [DEPTH],
  input  logic [ROW_W-1:0]     qRow  [DEPTH],
  input  logic [TXN_W-1:0]     qTxn  [DEPTH],
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic [ROW_W-1:0]     openRow [NUM_BANKS],
  output strobe_t              strb,
  output logic [IDX_W-1:0]     popIdx,
  output logic                 enqReady,
  output logic                 issValid,
  output logic [1:0]           issCmd,
  output logic [BANK_W-1:0]    issBank,
  output logic [ROW_W-1:0]     issRow,
  output logic [TXN_W-1:0]     issTxn,
  output logic                 issHoisted
);

  logic [TXN_W-1:0]     curTxn;
  logic [TXN_W-1:0]     nextTxn;
  logic [NUM_BANKS-1:0] curOnBank;
  logic                 anyCur;
  logic                 advance;
  logic [DEPTH-1:0]     hitElig, curElig, hoistElig;
  logic                 found;
  logic                 pickHoist;
  logic [IDX_W-1:0]     sel;

  assign nextTxn = curTxn + TXN_W'(1);

  always_comb begin
    curOnBank = '0;
    anyCur    = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (qValid[k] && qTxn[k] == curTxn) begin
        curOnBank[qBank[k]] = 1'b1;
        anyCur = 1'b1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      logic blocked, legal, rdy, inCur, inNext;
      blocked = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (j < k && qValid[j] && qTxn[j] == qTxn[k] && qBank[j] == qBank[k])
          blocked = 1'b1;
      end
      unique case (qCmd[k])
        CMD_PRE: legal = bankOpen[qBank[k]];
        CMD_ACT: legal = !bankOpen[qBank[k]];
        default: legal = bankOpen[qBank[k]] && (openRow[qBank[k]] == qRow[k]);
      endcase
      inCur  = qValid[k] && (qTxn[k] == curTxn);
      inNext = qValid[k] && (qTxn[k] == nextTxn);
      rdy    = bankReady[qBank[k]] && legal && !blocked;
      curElig[k]   = inCur && rdy;
      hitElig[k]   = inCur && rdy && isDataCmd(qCmd[k]);
      hoistElig[k] = inNext && rdy && !isDataCmd(qCmd[k]) && !curOnBank[qBank[k]];
    end
  end

  // lowest priority pass first; each later pass overrides when it has a candidate
  always_comb begin
    found     = 1'b0;
    pickHoist = 1'b0;
    sel       = '0;
    for (int k = DEPTH - 1; k >= 0; k--) begin
      if (hoistElig[k]) begin
        found = 1'b1; pickHoist = 1'b1; sel = IDX_W'(k);
      end
    end
    if (|curElig) begin
      for (int k = DEPTH - 1; k >= 0; k--) begin
        if (curElig[k]) begin
          found = 1'b1; pickHoist = 1'b0; sel = IDX_W'(k);
        end
      end
    end
    if (|hitElig) begin
      for (int k = DEPTH - 1; k >= 0; k--) begin
        if (hitElig[k]) begin
          found = 1'b1; pickHoist = 1'b0; sel = IDX_W'(k);
        end
      end
    end
  end

  assign enqReady   = (count < CNT_W'(DEPTH));
  assign issValid   = canIssue && found;
  assign issCmd     = qCmd[sel];
  assign issBank    = qBank[sel];
  assign issRow     = qRow[sel];
  assign issTxn     = qTxn[sel];
  assign issHoisted = pickHoist;
  assign popIdx     = sel;
  assign strb.pop   = issValid;
  assign strb.push  = pushValid && enqReady;
  assign advance    = (count != '0) && !anyCur;

  always_ff @(posedge clk) begin
    if (!rstN)        curTxn <= '0;
    else if (advance) curTxn <= nextTxn;
  end

  p_issue_gated_r2: assert property (@(posedge clk) disable iff (!rstN)
    issValid |-> (canIssue && bankReady[issBank]));

  p_data_in_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && isDataCmd(cmd_e'(issCmd))) |-> (issTxn == curTxn));

  p_hoist_next_r5: assert property (@(posedge clk) disable iff (!rstN)
    (issValid && issHoisted) |-> ((issTxn == nextTxn) && !isDataCmd(cmd_e'(issCmd))));

  p_txn_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curTxn) |-> (curTxn == $past(curTxn) + TXN_W'(1)));

endmodule

// File: rtl/txn_bank_scheduler.sv
module txn_bank_scheduler
  import bank_sched_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int NUM_BANKS = 8,
  parameter int ROW_W     = 14,
  parameter int TXN_W     = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         pushValid,
  input  logic [1:0]                   pushCmd,
  input  logic [$clog2(NUM_BANKS)-1:0] pushBank,
  input  logic [ROW_W-1:0]             pushRow,
  input  logic [TXN_W-1:0]             pushTxn,
  output logic                         enqReady,
  input  logic                         canIssue,
  input  logic [NUM_BANKS-1:0]         bankReady,
  output logic                         issValid,
  output logic [1:0]                   issCmd,
  output logic [$clog2(NUM_BANKS)-1:0] issBank,
  output logic [ROW_W-1:0]             issRow,
  output logic [TXN_W-1:0]             issTxn,
  output logic                         issHoisted
);

  localparam int BANK_W = $clog2(NUM_BANKS);
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int CNT_W  = $clog2(DEPTH + 1);

  strobe_t              strb;
  logic [IDX_W-1:0]     popIdx;
  logic [DEPTH-1:0]     qValid;
  cmd_e                 qCmd  [DEPTH];
  logic [BANK_W-1:0]    qBank [DEPTH];
  logic [ROW_W-1:0]     qRow  [DEPTH];
  logic [TXN_W-1:0]     qTxn  [DEPTH];
  logic [NUM_BANKS-1:0] bankOpen;
  logic [ROW_W-1:0]     openRow [NUM_BANKS];
  logic [CNT_W-1:0]     count;

  bank_sched_dp #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TXN_W(TXN_W),
    .BANK_W(BANK_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .popIdx(popIdx),
    .pushCmd(pushCmd), .pushBank(pushBank), .pushRow(pushRow), .pushTxn(pushTxn),
    .qValid(qValid), .qCmd(qCmd), .qBank(qBank), .qRow(qRow), .qTxn(qTxn),
    .bankOpen(bankOpen), .openRow(openRow), .count(count)
  );

  bank_sched_ctl #(
    .DEPTH(DEPTH), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .TXN_W(TXN_W),
    .BANK_W(BANK_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN), .canIssue(canIssue), .bankReady(bankReady),
    .pushValid(pushValid), .count(count), .qValid(qValid),
    .qCmd(qCmd), .qBank(qBank), .qRow(qRow), .qTxn(qTxn),
    .bankOpen(bankOpen), .openRow(openRow),
    .strb(strb), .popIdx(popIdx), .enqReady(enqReady),
    .issValid(issValid), .issCmd(issCmd), .issBank(issBank), .issRow(issRow),
    .issTxn(issTxn), .issHoisted(issHoisted)
  );

endmodule

// File: tb/txn_bank_scheduler_bench.sv
`timescale 1ns/1ps
module txn_bank_scheduler_bench;

  localparam int DEPTH = 8;
  localparam int NB    = 4;
  localparam int RW    = 4;
  localparam int TW    = 4;
  localparam logic [1:0] PRE = 2'd0, ACT = 2'd1, RD = 2'd2, WR = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          pushValid = 1'b0;
  logic [1:0]    pushCmd = 2'd0;
  logic [1:0]    pushBank = 2'd0;
  logic [RW-1:0] pushRow = '0;
  logic [TW-1:0] pushTxn = '0;
  logic          enqReady;
  logic          canIssue = 1'b0;
  logic [NB-1:0] bankReady = '1;
  logic          issValid;
  logic [1:0]    issCmd;
  logic [1:0]    issBank;
  logic [RW-1:0] issRow;
  logic [TW-1:0] issTxn;
  logic          issHoisted;

  int  checks = 0;
  int  fails  = 0;
  logic done  = 1'b0;

  always #2 clk = ~clk;

  txn_bank_scheduler #(.DEPTH(DEPTH), .NUM_BANKS(NB), .ROW_W(RW), .TXN_W(TW))
  u_txn_bank_scheduler (
    .clk(clk), .rstN(rstN), .pushValid(pushValid), .pushCmd(pushCmd),
    .pushBank(pushBank), .pushRow(pushRow), .pushTxn(pushTxn), .enqReady(enqReady),
    .canIssue(canIssue), .bankReady(bankReady), .issValid(issValid), .issCmd(issCmd),
    .issBank(issBank), .issRow(issRow), .issTxn(issTxn), .issHoisted(issHoisted)
  );

  task automatic push(input logic [1:0] c, input logic [1:0] b,
                      input logic [RW-1:0] r, input logic [TW-1:0] t);
    pushValid = 1'b1; pushCmd = c; pushBank = b; pushRow = r; pushTxn = t;
    @(negedge clk);
    pushValid = 1'b0;
  endtask

  // called at a falling edge; samples 1 ns later, returns at the next falling edge
  task automatic expectIss(input logic v, input logic [1:0] c, input logic [1:0] b,
                           input logic [RW-1:0] r, input logic [TW-1:0] t,
                           input logic h, input string tag);
    logic ok;
    #1;
    checks++;
    if (!v) ok = !issValid;
    else ok = issValid && issCmd == c && issBank == b && issRow == r &&
              issTxn == t && issHoisted == h;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got v=%0b cmd=%0d bank=%0d row=%0d txn=%0d hoist=%0b, expected v=%0b cmd=%0d bank=%0d row=%0d txn=%0d hoist=%0b",
               tag, issValid, issCmd, issBank, issRow, issTxn, issHoisted, v, c, b, r, t, h);
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) expectIss(1'b0, PRE, 2'd0, '0, '0, 1'b0, tag);
  endtask

  task automatic checkReady(input logic exp, input string tag);
    #1;
    checks++;
    if (enqReady !== exp) begin
      fails++;
      $display("FAIL %s: enqReady got %0b expected %0b", tag, enqReady, exp);
    end
    @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    doReset();
    // R1: empty queue, ready for entries, nothing issued even with the bus free
    canIssue = 1'b1;
    checkReady(1'b1, "R1 reset enqReady");
    idle(1, "R1 reset no issue");
    canIssue = 1'b0;

    // R4 R10: closed bank takes ACT, then the RD hits the row the ACT opened
    push(ACT, 2'd0, 4'd3, 4'd0);
    push(RD,  2'd0, 4'd3, 4'd0);
    idle(2, "R2 canIssue low holds");
    canIssue = 1'b1;
    expectIss(1'b1, ACT, 2'd0, 4'd3, 4'd0, 1'b0, "R4 ACT to closed bank");
    expectIss(1'b1, RD,  2'd0, 4'd3, 4'd0, 1'b0, "R10 RD after ACT opened row");
    idle(1, "R10 queue drained");

    // R3: younger row hit beats older ACT; R9 number advances to 1
    canIssue = 1'b0;
    push(ACT, 2'd1, 4'd2, 4'd1);
    push(RD,  2'd0, 4'd3, 4'd1);
    idle(2, "R2 canIssue low");
    canIssue = 1'b1;
    expectIss(1'b1, RD,  2'd0, 4'd3, 4'd1, 1'b0, "R3 row hit first");
    expectIss(1'b1, ACT, 2'd1, 4'd2, 4'd1, 1'b0, "R3 then older ACT");
    idle(1, "R3 drained");

    // R5 R6 R8: txn2 blocked on bank0; txn3 row prep pulled forward, txn4 ignored
    canIssue = 1'b0;
    bankReady = 4'b1110;
    push(RD,  2'd0, 4'd3, 4'd2);
    push(PRE, 2'd1, 4'd0, 4'd3);
    push(ACT, 2'd1, 4'd5, 4'd3);
    push(RD,  2'd1, 4'd5, 4'd3);
    push(ACT, 2'd2, 4'd1, 4'd4);
    idle(2, "R2 canIssue low");
    canIssue = 1'b1;
    expectIss(1'b1, PRE, 2'd1, 4'd0, 4'd3, 1'b1, "R5 hoisted PRE");
    expectIss(1'b1, ACT, 2'd1, 4'd5, 4'd3, 1'b1, "R5 hoisted ACT");
    expectIss(1'b0, PRE, 2'd0, '0, '0, 1'b0, "R6 R8 no early RD, no txn+2");
    bankReady = 4'b1111;
    expectIss(1'b1, RD,  2'd0, 4'd3, 4'd2, 1'b0, "R2 bank ready releases");
    expectIss(1'b0, PRE, 2'd0, '0, '0, 1'b0, "R9 R6 advance cycle idle");
    expectIss(1'b1, RD,  2'd1, 4'd5, 4'd3, 1'b0, "R9 txn3 data in order");
    expectIss(1'b1, ACT, 2'd2, 4'd1, 4'd4, 1'b1, "R5 R8 txn4 now next, hoisted");
    idle(1, "R5 drained");

    // R7: PRE behind its own txn's WR on same bank is not hoisted
    canIssue = 1'b0;
    bankReady = 4'b1110;
    push(RD,  2'd0, 4'd3, 4'd5);
    push(WR,  2'd1, 4'd5, 4'd6);
    push(PRE, 2'd1, 4'd0, 4'd6);
    push(ACT, 2'd1, 4'd7, 4'd6);
    idle(2, "R2 canIssue low");
    canIssue = 1'b1;
    idle(2, "R7 intra-txn conflict stays");
    bankReady = 4'b1111;
    expectIss(1'b1, RD,  2'd0, 4'd3, 4'd5, 1'b0, "R7 txn5 RD");
    expectIss(1'b0, PRE, 2'd0, '0, '0, 1'b0, "R9 advance cycle");
    expectIss(1'b1, WR,  2'd1, 4'd5, 4'd6, 1'b0, "R7 WR first");
    expectIss(1'b1, PRE, 2'd1, 4'd0, 4'd6, 1'b0, "R7 PRE in order");
    expectIss(1'b1, ACT, 2'd1, 4'd7, 4'd6, 1'b0, "R4 ACT after PRE closed bank");
    idle(1, "R7 drained");

    // R4: ACT to open bank and WR to wrong row wait; R10 queue fills
    push(ACT, 2'd0, 4'd9, 4'd6);
    push(WR,  2'd2, 4'd4, 4'd6);
    idle(2, "R4 illegal commands wait");
    canIssue = 1'b0;
    for (int i = 0; i < 6; i++) push(RD, 2'd3, 4'd0, 4'd7);
    checkReady(1'b0, "R10 full queue");

    // R1: reset clears queue and bank state
    doReset();
    canIssue = 1'b1;
    checkReady(1'b1, "R1 reset enqReady");
    idle(1, "R1 reset clears queue");
    push(RD, 2'd1, 4'd7, 4'd0);
    idle(2, "R1 banks closed after reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule